// File: doc/BRIEF.md
# Simulation Test Control Peripheral

A small write-only register block that software running on a simulated processor uses to report test outcomes and to end a run. It sits on a 32-bit word-addressed slave bus and claims a four-word aligned window at a parameterized base address. Three of those words are live registers: a control word, a result word and a name-pointer word. The fourth word answers with an error.

A write to the control word raises a one-cycle shutdown request, whatever the data. A write to the result word keeps the value and raises a one-cycle result strobe. A pass/fail flag goes with the strobe: zero means pass and anything else means fail. A write to the name-pointer word keeps the address and starts a sequential bus-master fetch of a fixed-length name string into an internal buffer. That buffer is shown on an output port, and its final byte is always zero so the string is terminated.

Reads, partial-width writes, misaligned addresses and writes to the spare word are rejected. Each gets an error response and sets a sticky error flag.

Top module: `simctl_port`

## Requirements
- R1: Reset clears the stored result code, the stored name pointer, the whole name buffer, the busy flag, the sticky error flag and every strobe and response output.
- R2: A request is claimed only when address bits [31:4] equal the same bits of BASE_ADDR. A claimed request gets exactly one response, s_ack_o or s_err_o, in the cycle after it is sampled. An unclaimed request gets no response and changes no state.
- R3: An accepted write to word 0 (address bits [3:2] = 0) pulses shutdown_o for one cycle in the cycle after the write, whatever the data value.
- R4: An accepted write to word 1 stores the data on result_code_o and pulses result_stb_o for one cycle in the cycle after the write. In that same cycle fail_o becomes 1 if the data is non-zero and 0 if it is zero, and fail_o then holds until the next accepted result write.
- R5: An accepted write to word 2 stores the data on name_ptr_o and sets busy_o. The block then issues NAME_BYTES/4 word reads at pointer, pointer+4, pointer+8 and so on. Each read holds m_req_o and m_addr_o until m_ack_i. busy_o clears after the last acknowledged read.
- R6: Fetched word k fills name bytes 4k to 4k+3 in little-endian order: name_o bits [32k+8j+7 : 32k+8j] hold bits [8j+7:8j] of word k. The top byte of name_o is always zero.
- R7: A claimed request is rejected if it is a read, if s_be_i is not 4'hF, if address bits [1:0] are not zero, or if it targets word 3. A rejected request gets s_err_o, not s_ack_o, and changes no register, strobe or fetch.
- R8: An accepted name-pointer write that arrives while busy_o is set abandons the current fetch and restarts it from word 0 at the new pointer.
- R9: err_o goes high in the same cycle as an error response and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid_i | input | 1 | Slave request valid |
| s_write_i | input | 1 | 1 = write, 0 = read |
| s_addr_i | input | 32 | Byte address |
| s_wdata_i | input | 32 | Write data |
| s_be_i | input | 4 | Byte enables |
| s_ack_o | output | 1 | Accepted response, one cycle after the request |
| s_err_o | output | 1 | Error response, one cycle after the request |
| m_req_o | output | 1 | Master read request |
| m_addr_o | output | 32 | Master read address |
| m_ack_i | input | 1 | Master read acknowledge, data valid |
| m_rdata_i | input | 32 | Master read data |
| shutdown_o | output | 1 | Shutdown request pulse |
| result_stb_o | output | 1 | Result strobe pulse |
| fail_o | output | 1 | Fail flag of the latest result |
| result_code_o | output | 32 | Stored result value |
| name_ptr_o | output | 32 | Stored name pointer |
| name_o | output | NAME_BYTES*8 | Name buffer, byte 0 in the low bits |
| busy_o | output | 1 | Name fetch in progress |
| err_o | output | 1 | Sticky rejected-access flag |

## Verification
The bench builds the block with its defaults: BASE_ADDR = 0xFFFF0000 and NAME_BYTES = 32. With these values a full eight-word fetch can be traced address by address, and the forced terminator byte lands on bits [255:248]. They also make the neighbouring addresses 0xFFFF0010 and 0xFFFEFFFC easy to reach, so window decoding can be probed on both sides. Fetches run with a memory that acknowledges every cycle and with one that stalls every other cycle, and one pointer is overwritten in the middle of a fetch.

// File: rtl/simctl_port.sv
module simctl_port #(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF_0000,
  parameter int          NAME_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid_i,
  input  logic                    s_write_i,
  input  logic [31:0]             s_addr_i,
  input  logic [31:0]             s_wdata_i,
  input  logic [3:0]              s_be_i,
  output logic                    s_ack_o,
  output logic                    s_err_o,
  output logic                    m_req_o,
  output logic [31:0]             m_addr_o,
  input  logic                    m_ack_i,
  input  logic [31:0]             m_rdata_i,
  output logic                    shutdown_o,
  output logic                    result_stb_o,
  output logic                    fail_o,
  output logic [31:0]             result_code_o,
  output logic [31:0]             name_ptr_o,
  output logic [NAME_BYTES*8-1:0] name_o,
  output logic                    busy_o,
  output logic                    err_o
);
  localparam int NWORDS = NAME_BYTES / 4;
  localparam int CW     = $clog2(NWORDS);
  localparam logic [CW-1:0] LAST = CW'(NWORDS - 1);

  logic [31:0]   wbuf_q [NWORDS];
  logic [CW-1:0] cnt_q;

  wire       hit    = s_valid_i && (s_addr_i[31:4] == BASE_ADDR[31:4]);
  wire [1:0] idx    = s_addr_i[3:2];
  wire       good   = hit && s_write_i && (s_be_i == 4'hF) &&
                      (s_addr_i[1:0] == 2'b00) && (idx != 2'd3);
  wire       wr_ctl = good && (idx == 2'd0);
  wire       wr_res = good && (idx == 2'd1);
  wire       wr_ptr = good && (idx == 2'd2);

  assign m_req_o  = busy_o;
  assign m_addr_o = name_ptr_o + (32'(cnt_q) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ack_o       <= 1'b0;
      s_err_o       <= 1'b0;
      shutdown_o    <= 1'b0;
      result_stb_o  <= 1'b0;
      fail_o        <= 1'b0;
      result_code_o <= '0;
      name_ptr_o    <= '0;
      err_o         <= 1'b0;
    end else begin
      s_ack_o      <= good;
      s_err_o      <= hit && !good;
      shutdown_o   <= wr_ctl;
      result_stb_o <= wr_res;
      if (hit && !good) err_o <= 1'b1;
      if (wr_res) begin
        result_code_o <= s_wdata_i;
        fail_o        <= |s_wdata_i;
      end
      if (wr_ptr) name_ptr_o <= s_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      for (int k = 0; k < NWORDS; k++) wbuf_q[k] <= '0;
    end else if (wr_ptr) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o && m_ack_i) begin
      wbuf_q[cnt_q] <= m_rdata_i;
      cnt_q         <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_o <= 1'b0;
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_name
    if (k == NWORDS - 1) begin : g_term
      assign name_o[32*k +: 32] = {8'h00, wbuf_q[k][23:0]};
    end else begin : g_body
      assign name_o[32*k +: 32] = wbuf_q[k];
    end
  end
endmodule

// File: rtl/simctl_port_chk.sv
module simctl_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid_i,
  input logic        s_ack_o,
  input logic        s_err_o,
  input logic        m_req_o,
  input logic [31:0] m_addr_o,
  input logic        m_ack_i,
  input logic        shutdown_o,
  input logic        result_stb_o,
  input logic        fail_o,
  input logic        err_o
);
  p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ack_o && s_err_o));
  p_shut_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> !shutdown_o);
  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_stb_o |=> !result_stb_o);
  p_fail_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !result_stb_o |-> $stable(fail_o));
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_o && !m_ack_i && !s_valid_i) |=> (m_req_o && $stable(m_addr_o)));
  p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_err_o |-> err_o);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind simctl_port simctl_port_chk u_chk (.*);

// File: tb/simctl_port_bench.sv
module simctl_port_bench;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam int NB = 32;
  localparam int NWD = NB / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_write = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic [3:0] s_be = '0;
  logic s_ack, s_err, m_req, m_ack, shut, stb, fail, busy, err;
  logic [31:0] m_addr, m_rdata, code, ptr;
  logic [NB*8-1:0] name;
  logic ack_en = 1'b1, stall_mode = 1'b0;

  always #2 clk = ~clk;

  simctl_port u_simctl_port (
    .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid), .s_write_i(s_write),
    .s_addr_i(s_addr), .s_wdata_i(s_wdata), .s_be_i(s_be),
    .s_ack_o(s_ack), .s_err_o(s_err), .m_req_o(m_req), .m_addr_o(m_addr),
    .m_ack_i(m_ack), .m_rdata_i(m_rdata), .shutdown_o(shut),
    .result_stb_o(stb), .fail_o(fail), .result_code_o(code),
    .name_ptr_o(ptr), .name_o(name), .busy_o(busy), .err_o(err));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h11, a[7:0] + 8'h29, a[23:16] ^ a[7:0]};
  endfunction

  assign m_ack   = m_req && ack_en;
  assign m_rdata = memf(m_addr);

  always @(negedge clk) if (stall_mode) ack_en <= ~ack_en;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic ack, errr, sh, st, fl;
    logic [31:0] cd, pt;
  } item_t;
  item_t exq[$];
  string rqq[$];
  logic [31:0] acklog[$];

  logic [31:0] mdl_code = '0, mdl_ptr = '0;
  logic mdl_fail = 1'b0;

  task automatic access(input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic wr, input string rq);
    item_t it;
    logic hit, good;
    hit  = (a[31:4] == BASE[31:4]);
    good = hit && wr && be == 4'hF && a[1:0] == 2'b00 && a[3:2] != 2'd3;
    if (good && a[3:2] == 2'd1) begin mdl_code = d; mdl_fail = (d != 0); end
    if (good && a[3:2] == 2'd2) mdl_ptr = d;
    it.ack = good; it.errr = hit && !good;
    it.sh = good && a[3:2] == 2'd0; it.st = good && a[3:2] == 2'd1;
    it.fl = mdl_fail; it.cd = mdl_code; it.pt = mdl_ptr;
    if (hit) begin exq.push_back(it); rqq.push_back(rq); end
    @(negedge clk);
    s_valid = 1'b1; s_write = wr; s_addr = a; s_wdata = d; s_be = be;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (m_req && m_ack) acklog.push_back(m_addr);
    #1;
    if (rst_n && (s_ack || s_err || shut || stb)) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", {s_ack, s_err, shut, stb}, 0);
      end else begin
        item_t e;
        string r;
        e = exq.pop_front(); r = rqq.pop_front();
        chk({s_ack, s_err} == {e.ack, e.errr}, r, "ack/err", {s_ack, s_err}, {e.ack, e.errr});
        chk(shut == e.sh, r, "shutdown", shut, e.sh);
        chk(stb == e.st, r, "result strobe", stb, e.st);
        chk(fail == e.fl, r, "fail flag", fail, e.fl);
        chk(code == e.cd, r, "result code", code, e.cd);
        chk(ptr == e.pt, r, "name pointer", ptr, e.pt);
      end
    end
  end

  task automatic drain(input string rq);
    repeat (2) @(negedge clk);
    chk(exq.size() == 0, rq, "missing response", exq.size(), 0);
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    @(negedge clk);
    while (busy && n < 400) begin @(negedge clk); n++; end
    chk(!busy, rq, "fetch completes", busy, 0);
  endtask

  function automatic logic [255:0] exp_name(input logic [31:0] p);
    logic [255:0] v;
    for (int k = 0; k < NWD; k++) v[32*k +: 32] = memf(p + 32'(4*k));
    v[255:248] = 8'h00;
    return v;
  endfunction

  task automatic check_fetch(input logic [31:0] p, input string rq);
    int n = acklog.size();
    bit ok = (n >= NWD);
    for (int k = 0; k < NWD; k++)
      if (ok && acklog[n - NWD + k] != p + 32'(4*k)) ok = 1'b0;
    chk(ok, rq, "fetch address sequence", n, NWD);
    chk(name == exp_name(p), "R6", "name buffer", name, exp_name(p));
    chk(name[255:248] == 8'h00, "R6", "terminator byte", name[255:248], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({code, ptr, busy, err, fail, s_ack, s_err, shut, stb} == 0, "R1",
        "reset outputs", {code, ptr, busy, err, fail}, 0);
    chk(name == 0, "R1", "reset name", name, 0);

    // R3 control writes with any data
    access(BASE + 0, 32'hDEAD_BEEF, 4'hF, 1'b1, "R3");
    access(BASE + 0, 32'h0, 4'hF, 1'b1, "R3");
    drain("R3");

    // R4 results: pass, fail, hold across other writes, pass again
    access(BASE + 4, 32'h0, 4'hF, 1'b1, "R4");
    access(BASE + 4, 32'h7, 4'hF, 1'b1, "R4");
    access(BASE + 0, 32'h1, 4'hF, 1'b1, "R4");
    access(BASE + 4, 32'h8000_0000, 4'hF, 1'b1, "R4");
    access(BASE + 4, 32'h0, 4'hF, 1'b1, "R4");
    drain("R4");

    // R5 / R6 fetch with a memory that never stalls
    acklog.delete();
    access(BASE + 8, 32'h1000_0040, 4'hF, 1'b1, "R5");
    wait_idle("R5");
    check_fetch(32'h1000_0040, "R5");
    chk(acklog.size() == NWD, "R5", "read count", acklog.size(), NWD);
    drain("R5");

    // R7 rejected accesses; R9 sticky flag
    access(BASE + 4, 32'h0, 4'hF, 1'b0, "R7");
    chk(err, "R9", "error flag set", err, 1);
    access(BASE + 4, 32'h55, 4'h3, 1'b1, "R7");
    access(BASE + 12, 32'h66, 4'hF, 1'b1, "R7");
    access(BASE + 6, 32'h77, 4'hF, 1'b1, "R7");
    access(BASE + 8, 32'h2222_0000, 4'hF, 1'b0, "R7");
    drain("R7");
    chk(!busy, "R7", "no fetch from rejected write", busy, 0);
    chk(name == exp_name(32'h1000_0040), "R7", "name kept", name, exp_name(32'h1000_0040));
    access(BASE + 4, 32'h3, 4'hF, 1'b1, "R9");
    drain("R9");
    chk(err, "R9", "error flag held", err, 1);

    // R2 unclaimed neighbours
    access(BASE + 16, 32'h9, 4'hF, 1'b1, "R2");
    access(BASE - 4, 32'h9, 4'hF, 1'b1, "R2");
    drain("R2");
    chk(code == 32'h3 && !busy, "R2", "unclaimed has no effect", code, 32'h3);

    // R5 fetch with stalls
    acklog.delete();
    stall_mode = 1'b1;
    access(BASE + 8, 32'h2000_0100, 4'hF, 1'b1, "R5");
    wait_idle("R5");
    stall_mode = 1'b0;
    @(negedge clk);
    ack_en = 1'b1;
    check_fetch(32'h2000_0100, "R5");
    drain("R5");

    // R8 restart in the middle of a fetch
    acklog.delete();
    access(BASE + 8, 32'h3000_0000, 4'hF, 1'b1, "R8");
    chk(busy, "R8", "busy before restart", busy, 1);
    access(BASE + 8, 32'h4000_0080, 4'hF, 1'b1, "R8");
    wait_idle("R8");
    check_fetch(32'h4000_0080, "R8");
    chk(acklog.size() > NWD, "R8", "first fetch was cut", acklog.size(), NWD + 1);
    drain("R8");

    // R1 reset in mid-run clears everything
    access(BASE + 8, 32'h5000_0000, 4'hF, 1'b1, "R1");
    rst_n = 1'b0;
    exq.delete(); rqq.delete();
    mdl_code = '0; mdl_ptr = '0; mdl_fail = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({code, ptr, busy, err, fail} == 0, "R1", "second reset outputs",
        {code, ptr, busy, err, fail}, 0);
    chk(name == 0, "R1", "second reset name", name, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule